// File: doc/BRIEF.md
# Slow Reset Pin Filter with Write Gating

This block cleans up a slow, bouncy active-low reset pin. The pin is brought into the system clock domain by a short synchroniser. It is then sampled into a shift window, but only on cycles where a one-cycle sample enable is high; the enable nominally runs at 8 Hz. The filtered reset changes level only when every stage of the window agrees. A bounce of up to two sample periods is therefore ignored, and a level that is held for more than three and a half periods is always taken.

The filtered reset also closes the write path of a serial register interface. The serial engine pulses an acknowledge-slot strobe for each byte and marks the first byte of a transaction. The block answers every first byte with an acknowledge. It answers every later byte with an acknowledge only if the filtered reset is released. A power-on reset forces the filtered reset low whatever the pin level is. When the filtered reset rises, the block emits a one-cycle pulse that tells the device to enter read mode.

Top module: `slow_reset_filter`

## Requirements
- R1: While `por_n_i` is low, `filt_rst_n_o` and `wr_permit_o` are 0, whatever the pin level is, and `ack_valid_o` is 0.
- R2: The window advances only in cycles where `smp_tick_i` is 1; with no sample enables, any pin activity leaves `filt_rst_n_o` unchanged.
- R3: After `WIN_DEPTH` (default 3) consecutive low samples, `filt_rst_n_o` is 0 one clock after the sample edge that completed the run.
- R4: After `WIN_DEPTH` consecutive high samples, `filt_rst_n_o` is 1 one clock after the sample edge that completed the run.
- R5: A run of one or two samples at the opposite level, in either direction, leaves `filt_rst_n_o` unchanged.
- R6: After power-on reset is released, the window starts all low, so `filt_rst_n_o` stays 0 until three high samples have been taken.
- R7: An acknowledge slot with `ack_first_i`=1 always gives `ack_valid_o`=1 and `ack_o`=1 one clock later.
- R8: An acknowledge slot with `ack_first_i`=0 gives `ack_valid_o`=1 one clock later. In that cycle `ack_o` equals the `filt_rst_n_o` level of the slot cycle, so 0 means not-acknowledge while the reset is held.
- R9: `wr_permit_o` equals `filt_rst_n_o`. `rd_mode_enter_o` is high for exactly one clock, in the first cycle in which `filt_rst_n_o` is 1 after being 0.
- R10: If an acknowledge slot falls in the cycle just before the filtered reset rises, it is decided with the old level. The result is a not-acknowledge on the same clock as the read-mode pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| por_n_i | input | 1 | Asynchronous power-on reset, active low |
| smp_tick_i | input | 1 | One-cycle sample enable (nominally 8 Hz) |
| rst_pin_n_i | input | 1 | Raw reset pin, active low, asynchronous |
| ack_slot_i | input | 1 | Pulse at a byte's acknowledge slot |
| ack_first_i | input | 1 | The slot belongs to the first byte of a write |
| filt_rst_n_o | output | 1 | Filtered reset, active low |
| wr_permit_o | output | 1 | Register writes allowed |
| rd_mode_enter_o | output | 1 | One-cycle pulse on release into read mode |
| ack_valid_o | output | 1 | Acknowledge decision valid (one clock after slot) |
| ack_o | output | 1 | 1 = acknowledge, 0 = not-acknowledge |

## Verification
The acknowledge decision for a later byte can fall in the same clock as the release of the filtered reset. The bench counts sample enables after power-on reset and raises a non-first acknowledge slot in the cycle right after the third high sample. The decision then registers on the same edge as the release. It is judged correct when `ack_o` is 0 while `filt_rst_n_o` and `rd_mode_enter_o` are both 1, and when the next slot is acknowledged.

// File: rtl/srf_pkg.sv
package srf_pkg;
   typedef struct packed {
      logic valid;
      logic ack;
   } ack_dec_t;

   localparam logic LVL_HELD     = 1'b0;
   localparam logic LVL_RELEASED = 1'b1;
endpackage

// File: rtl/srf_sync.sv
module srf_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic arst_n_i,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad
      $error("srf_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] stg_q;

   always_ff @(posedge clk_i or negedge arst_n_i) begin
      if (!arst_n_i) stg_q <= '0;
      else           stg_q <= {stg_q[STAGES-2:0], d_i};
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/srf_window.sv
module srf_window #(
   parameter int unsigned DEPTH = 3
) (
   input  logic             clk_i,
   input  logic             arst_n_i,
   input  logic             smp_en_i,
   input  logic             d_i,
   output logic [DEPTH-1:0] win_o,
   output logic             all_lo_o,
   output logic             all_hi_o
);
   if (DEPTH < 2) begin : g_bad
      $error("srf_window: DEPTH must be at least 2");
   end

   logic [DEPTH-1:0] win_q;

   always_ff @(posedge clk_i or negedge arst_n_i) begin
      if (!arst_n_i)     win_q <= '0;
      else if (smp_en_i) win_q <= {win_q[DEPTH-2:0], d_i};
   end

   // per-stage agreement chain built stage by stage
   logic [DEPTH-1:0] lo_chain, hi_chain;
   for (genvar g = 0; g < DEPTH; g++) begin : g_agree
      if (g == 0) begin : g_head
         assign lo_chain[g] = ~win_q[g];
         assign hi_chain[g] =  win_q[g];
      end else begin : g_tail
         assign lo_chain[g] = lo_chain[g-1] & ~win_q[g];
         assign hi_chain[g] = hi_chain[g-1] &  win_q[g];
      end
   end

   assign win_o    = win_q;
   assign all_lo_o = lo_chain[DEPTH-1];
   assign all_hi_o = hi_chain[DEPTH-1];
endmodule

// File: rtl/srf_level.sv
module srf_level (
   input  logic clk_i,
   input  logic arst_n_i,
   input  logic all_lo_i,
   input  logic all_hi_i,
   output logic lvl_o,
   output logic rise_o
);
   import srf_pkg::*;

   logic lvl_q, lvl_d, rise_q;

   always_comb begin
      lvl_d = lvl_q;
      if (all_hi_i)      lvl_d = LVL_RELEASED;
      else if (all_lo_i) lvl_d = LVL_HELD;
   end

   always_ff @(posedge clk_i or negedge arst_n_i) begin
      if (!arst_n_i) begin
         lvl_q  <= LVL_HELD;
         rise_q <= 1'b0;
      end else begin
         lvl_q  <= lvl_d;
         rise_q <= lvl_d & ~lvl_q;
      end
   end

   assign lvl_o  = lvl_q;
   assign rise_o = rise_q;
endmodule

// File: rtl/srf_ackgate.sv
module srf_ackgate (
   input  logic clk_i,
   input  logic arst_n_i,
   input  logic slot_i,
   input  logic first_i,
   input  logic permit_i,
   output logic valid_o,
   output logic ack_o
);
   import srf_pkg::*;

   ack_dec_t dec_q, dec_d;

   always_comb begin
      dec_d.valid = slot_i;
      dec_d.ack   = slot_i & (first_i | permit_i);
   end

   always_ff @(posedge clk_i or negedge arst_n_i) begin
      if (!arst_n_i) dec_q <= '0;
      else           dec_q <= dec_d;
   end

   assign valid_o = dec_q.valid;
   assign ack_o   = dec_q.ack;
endmodule

// File: rtl/slow_reset_filter.sv
module slow_reset_filter #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned WIN_DEPTH   = 3
) (
   input  logic clk_i,
   input  logic por_n_i,
   input  logic smp_tick_i,
   input  logic rst_pin_n_i,
   input  logic ack_slot_i,
   input  logic ack_first_i,
   output logic filt_rst_n_o,
   output logic wr_permit_o,
   output logic rd_mode_enter_o,
   output logic ack_valid_o,
   output logic ack_o
);
   logic                 pin_sync;
   logic [WIN_DEPTH-1:0] win_q;
   logic                 all_lo, all_hi;
   logic                 lvl;

   srf_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .arst_n_i(por_n_i),
      .d_i     (rst_pin_n_i),
      .q_o     (pin_sync)
   );

   srf_window #(.DEPTH(WIN_DEPTH)) u_win (
      .clk_i   (clk_i),
      .arst_n_i(por_n_i),
      .smp_en_i(smp_tick_i),
      .d_i     (pin_sync),
      .win_o   (win_q),
      .all_lo_o(all_lo),
      .all_hi_o(all_hi)
   );

   srf_level u_lvl (
      .clk_i   (clk_i),
      .arst_n_i(por_n_i),
      .all_lo_i(all_lo),
      .all_hi_i(all_hi),
      .lvl_o   (lvl),
      .rise_o  (rd_mode_enter_o)
   );

   srf_ackgate u_ack (
      .clk_i   (clk_i),
      .arst_n_i(por_n_i),
      .slot_i  (ack_slot_i),
      .first_i (ack_first_i),
      .permit_i(lvl),
      .valid_o (ack_valid_o),
      .ack_o   (ack_o)
   );

   assign filt_rst_n_o = lvl;
   assign wr_permit_o  = lvl;
endmodule

// File: rtl/srf_checker.sv
module srf_checker #(
   parameter int unsigned WIN_DEPTH = 3
) (
   input logic                 clk_i,
   input logic                 por_n_i,
   input logic                 smp_tick_i,
   input logic                 ack_slot_i,
   input logic                 ack_first_i,
   input logic [WIN_DEPTH-1:0] win_q,
   input logic                 filt_rst_n_o,
   input logic                 wr_permit_o,
   input logic                 rd_mode_enter_o,
   input logic                 ack_valid_o,
   input logic                 ack_o
);
   assert_por_holds_R1: assert property (@(posedge clk_i)
      !por_n_i |-> (!filt_rst_n_o && !wr_permit_o && !ack_valid_o));

   assert_window_frozen_R2: assert property (@(posedge clk_i) disable iff (!por_n_i)
      !smp_tick_i |=> $stable(win_q));

   assert_all_low_takes_R3: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (win_q == '0) |=> !filt_rst_n_o);

   assert_all_high_takes_R4: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (&win_q) |=> filt_rst_n_o);

   assert_first_acked_R7: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (ack_slot_i && ack_first_i) |=> (ack_valid_o && ack_o));

   assert_held_nacks_R8: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (ack_slot_i && !ack_first_i && !filt_rst_n_o) |=> (ack_valid_o && !ack_o));

   assert_rise_pulse_R9: assert property (@(posedge clk_i) disable iff (!por_n_i)
      $rose(filt_rst_n_o) |-> rd_mode_enter_o);

   assert_pulse_single_R9: assert property (@(posedge clk_i) disable iff (!por_n_i)
      rd_mode_enter_o |=> !rd_mode_enter_o);

   assert_valid_follows_slot_R10: assert property (@(posedge clk_i) disable iff (!por_n_i)
      ack_valid_o |-> $past(ack_slot_i));

   always_comb begin
      assert_permit_tracks_R9: assert (wr_permit_o == filt_rst_n_o);
   end
endmodule

bind slow_reset_filter srf_checker #(.WIN_DEPTH(WIN_DEPTH)) u_chk (
   .clk_i          (clk_i),
   .por_n_i        (por_n_i),
   .smp_tick_i     (smp_tick_i),
   .ack_slot_i     (ack_slot_i),
   .ack_first_i    (ack_first_i),
   .win_q          (win_q),
   .filt_rst_n_o   (filt_rst_n_o),
   .wr_permit_o    (wr_permit_o),
   .rd_mode_enter_o(rd_mode_enter_o),
   .ack_valid_o    (ack_valid_o),
   .ack_o          (ack_o)
);

// File: tb/slow_reset_filter_tb_top.sv
module slow_reset_filter_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int TDIV       = 16;
   localparam int NVEC       = 10;
   // {pin level, sample count[3:0], expected filtered level}
   localparam logic [5:0] VEC [NVEC] = '{
      {1'b0, 4'd2, 1'b1},   // R5 low glitch of 2 rejected
      {1'b1, 4'd3, 1'b1},
      {1'b0, 4'd4, 1'b0},   // R3 low of 4 taken
      {1'b1, 4'd2, 1'b0},   // R5 high glitch rejected
      {1'b0, 4'd1, 1'b0},
      {1'b1, 4'd3, 1'b1},   // R4
      {1'b0, 4'd3, 1'b0},   // R3
      {1'b1, 4'd1, 1'b0},   // R5
      {1'b0, 4'd1, 1'b0},
      {1'b1, 4'd5, 1'b1}    // R4
   };

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic tick = 1'b0;
   logic pin_n = 1'b1;
   logic slot = 1'b0;
   logic first = 1'b0;
   logic tick_en = 1'b0;
   logic filt, permit, rel, avld, ack;
   int   tcnt = 0;
   int   errors = 0;
   int   checks = 0;
   int   rel_seen = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) begin
      if (!tick_en) begin
         tcnt <= 0;
         tick <= 1'b0;
      end else begin
         tcnt <= (tcnt == TDIV-1) ? 0 : tcnt + 1;
         tick <= (tcnt == TDIV-1);
      end
      if (rel === 1'b1) rel_seen <= rel_seen + 1;
   end

   slow_reset_filter dut_i (
      .clk_i          (clk),
      .por_n_i        (por_n),
      .smp_tick_i     (tick),
      .rst_pin_n_i    (pin_n),
      .ack_slot_i     (slot),
      .ack_first_i    (first),
      .filt_rst_n_o   (filt),
      .wr_permit_o    (permit),
      .rd_mode_enter_o(rel),
      .ack_valid_o    (avld),
      .ack_o          (ack)
   );

   task automatic chk(input logic got, input logic exp, input string req);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
      end
   endtask

   task automatic wait_ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         while (tick !== 1'b1) @(posedge clk);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic prev;
      int   rises;
      int   base;
      // R1: reset state, pin high
      repeat (5) @(negedge clk);
      chk(filt, 1'b0, "R1 filt during por");
      chk(permit, 1'b0, "R1 permit during por");
      chk(avld, 1'b0, "R1 ack_valid during por");

      @(negedge clk);
      por_n   = 1'b1;
      tick_en = 1'b1;
      // R7: first byte before release
      @(negedge clk); slot = 1'b1; first = 1'b1;
      @(negedge clk); slot = 1'b0; first = 1'b0;
      chk(avld, 1'b1, "R7 valid");
      chk(ack, 1'b1, "R7 first byte ack");
      // R8: second byte refused
      @(negedge clk); slot = 1'b1;
      @(negedge clk); slot = 1'b0;
      chk(avld, 1'b1, "R8 valid byte2");
      chk(ack, 1'b0, "R8 byte2 nack while held");

      // R6: two high samples not enough
      wait_ticks(2);
      @(negedge clk); @(negedge clk);
      chk(filt, 1'b0, "R6 held after two samples");
      chk(permit, 1'b0, "R6 permit after two samples");

      // R10: slot in cycle just before release
      wait_ticks(1);
      @(negedge clk); slot = 1'b1;
      @(negedge clk); slot = 1'b0;
      chk(filt, 1'b1, "R6 released after three samples");
      chk(rel, 1'b1, "R9 read-mode pulse");
      chk(avld, 1'b1, "R10 valid on release edge");
      chk(ack, 1'b0, "R10 old level used");
      @(negedge clk);
      chk(rel, 1'b0, "R9 pulse one cycle");
      chk(permit, 1'b1, "R9 permit follows filt");
      slot = 1'b1;
      @(negedge clk); slot = 1'b0;
      chk(ack, 1'b1, "R8 byte2 ack when released");

      // vector table: R3 R4 R5
      base  = rel_seen;
      prev  = 1'b1;
      rises = 0;
      for (int v = 0; v < NVEC; v++) begin
         @(negedge clk);
         pin_n = VEC[v][5];
         wait_ticks(int'(VEC[v][4:1]));
         @(negedge clk); @(negedge clk);
         chk(filt, VEC[v][0], $sformatf("R3/R4/R5 vector %0d", v));
         if (VEC[v][0] && !prev) rises++;
         prev = VEC[v][0];
      end
      checks++;
      if (rel_seen - base != rises) begin
         errors++;
         $display("FAIL R9: got %0d pulses expected %0d", rel_seen - base, rises);
      end

      // R2: no sample enables, pin low for a long time
      @(negedge clk);
      tick_en = 1'b0;
      pin_n   = 1'b0;
      repeat (80) @(negedge clk);
      chk(filt, 1'b1, "R2 no change without samples");
      pin_n   = 1'b1;
      tick_en = 1'b1;
      repeat (4) @(negedge clk);

      // R1: power-on reset mid-run with pin high
      por_n = 1'b0;
      #1;
      chk(filt, 1'b0, "R1 async por");
      chk(permit, 1'b0, "R1 permit async por");
      @(negedge clk);
      por_n = 1'b1;
      repeat (3) @(negedge clk);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule